// File: doc/BRIEF.md
# Edge-Latched Interrupt Priority Encoder

This block collects seven active-low interrupt request lines from peripherals and presents them to a processor with level-sensitive, three-bit priority inputs. Each line passes through a two-flop synchroniser. A synchronised high-to-low transition sets that source's pending flag. The flag holds after the line goes high again, so a short pulse from a peripheral is never lost, and a line held low asks for service only once.

The highest pending source drives the active-low priority output. When the processor drives all function code lines high, it is running an interrupt acknowledge cycle. The block then raises an acknowledge-active output, which the bus logic uses to end the cycle with an autovector request. The level shown on address lines A3..A1 during that cycle names the source being served, and only that source's pending flag is cleared.

Top module: `irq_edge_prio`

## Requirements
- R1: After synchronous reset, no source is pending and `ipl_n_o` reads 3'b111. Reset also presets the synchronisers to the idle-high state, so releasing reset never creates a request.
- R2: A high-to-low transition on `irq_n_i[k]` makes source level k+1 pending. The output reflects it at the third rising clock edge after the input changes.
- R3: A pending flag stays set after its line returns high, until it is cleared by an acknowledge.
- R4: A line held low after its flag has been cleared does not set the flag again. Only a new falling edge does.
- R5: `ipl_n_o` is the bitwise inverse of the highest pending level (level 7 is highest). It is 3'b111 when nothing is pending.
- R6: `iack_o` is high in exactly those cycles in which `fc_i` is 3'b111.
- R7: In a clock where `iack_o` is high and `ack_lvl_i` is a nonzero level L, the flag of level L clears at that edge and every other flag keeps its value. If `ack_lvl_i` is 0, or `fc_i` is not 3'b111, no flag is cleared.
- R8: If a new synchronised falling edge on a source arrives in the same clock as that source's clear, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_n_i | input | 7 | Active-low requests; bit k is priority level k+1 |
| fc_i | input | 3 | Processor function code lines |
| ack_lvl_i | input | 3 | Address bits A3..A1 during acknowledge: the level being served |
| ipl_n_o | output | 3 | Active-low encoded priority to the processor |
| iack_o | output | 1 | High during an acknowledge cycle; used to request autovectoring |

## Verification
Directed sequences separate the main behaviours. A lone pulse shows the three-edge latency and that the flag is sticky. Two overlapping sources show that priority ordering holds and that only the served flag is cleared. A line held low across its clear shows edge triggering instead of level triggering. A fresh edge timed to meet its own clear shows that the set takes precedence. Acknowledges with level 0 or an incomplete function code show that no clear happens. Long random runs then mix sparse line toggles with frequent acknowledges at random levels. An independent bench model is compared every cycle, which exercises many simultaneous pending sources.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned IRQ_SRCS = 7;
    localparam int unsigned LVL_W    = $clog2(IRQ_SRCS + 1);
    localparam int unsigned FC_W     = 3;

    typedef logic [IRQ_SRCS-1:0] src_vec_t;
    typedef logic [LVL_W-1:0]    lvl_t;
    typedef logic [FC_W-1:0]     fc_t;

    // Per-cycle control applied to the pending bank
    typedef struct packed {
        src_vec_t set;
        src_vec_t clr;
    } pend_ctl_t;

    // Highest set bit index plus one; zero when empty
    function automatic lvl_t top_level(src_vec_t v);
        lvl_t l = '0;
        for (int k = 0; k < IRQ_SRCS; k++) begin
            if (v[k]) l = lvl_t'(k + 1);
        end
        return l;
    endfunction

    // One-hot source mask for a level; zero for level 0 or out of range
    function automatic src_vec_t level_mask(lvl_t l);
        src_vec_t m = '0;
        for (int k = 0; k < IRQ_SRCS; k++) begin
            if (int'(l) == k + 1) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t line_n_i,
    output src_vec_t fall_o
);

    for (genvar k = 0; k < IRQ_SRCS; k++) begin : g_src
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= line_n_i[k];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign fall_o[k] = prev_q & ~sync_q;
    end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pend_ctl_t ctl_i,
    output src_vec_t  pend_o
);

    for (genvar k = 0; k < IRQ_SRCS; k++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (ctl_i.set[k])
                flag_q <= 1'b1;
            else if (ctl_i.clr[k])
                flag_q <= 1'b0;
        end

        assign pend_o[k] = flag_q;
    end

endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
    import irq_pkg::*;
(
    input  src_vec_t pend_i,
    output lvl_t     ipl_n_o
);

    always_comb begin
        ipl_n_o = ~top_level(pend_i);
    end

endmodule

// File: rtl/irq_edge_prio.sv
module irq_edge_prio
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [6:0]       irq_n_i,
    input  logic [FC_W-1:0]  fc_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    output logic [LVL_W-1:0] ipl_n_o,
    output logic             iack_o
);

    src_vec_t  fall_vec;
    src_vec_t  clr_vec;
    src_vec_t  pend_q;
    pend_ctl_t ctl;

    irq_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_n_i (irq_n_i),
        .fall_o   (fall_vec)
    );

    always_comb begin
        iack_o  = &fc_i;
        clr_vec = iack_o ? level_mask(ack_lvl_i) : '0;
        ctl.set = fall_vec;
        ctl.clr = clr_vec;
    end

    irq_pend_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .ctl_i  (ctl),
        .pend_o (pend_q)
    );

    irq_lvl_enc u_enc (
        .pend_i  (pend_q),
        .ipl_n_o (ipl_n_o)
    );

endmodule

// File: rtl/irq_edge_prio_chk.sv
module irq_edge_prio_chk
    import irq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input lvl_t     ipl_n_o,
    input logic     iack_o,
    input fc_t      fc_i,
    input src_vec_t pend_q,
    input src_vec_t fall_vec,
    input src_vec_t clr_vec
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ipl_n_o == '1));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(fall_vec)) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

    p_idle_out_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> (ipl_n_o == '1));

    p_busy_out_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |-> (ipl_n_o != '1));

    p_ack_needs_fc_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |-> (iack_o && fc_i == '1));

    p_one_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    p_clear_done_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(clr_vec) & ~$past(fall_vec) & pend_q) == '0));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(fall_vec) & ~pend_q) == '0));

endmodule

bind irq_edge_prio irq_edge_prio_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ipl_n_o  (ipl_n_o),
    .iack_o   (iack_o),
    .fc_i     (fc_i),
    .pend_q   (pend_q),
    .fall_vec (fall_vec),
    .clr_vec  (clr_vec)
);

// File: tb/irq_edge_prio_tb_top.sv
`timescale 1ns/1ps
module irq_edge_prio_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] irq_n = '1;
    logic [2:0] fc = '0;
    logic [2:0] ack_lvl = '0;
    logic [2:0] ipl_n;
    logic       iack;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_edge_prio dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_n_i   (irq_n),
        .fc_i      (fc),
        .ack_lvl_i (ack_lvl),
        .ipl_n_o   (ipl_n),
        .iack_o    (iack)
    );

    // Reference model written from the requirements
    logic [6:0] r_a, r_b, r_c, r_pend;

    function automatic logic [6:0] served_mask(logic [2:0] f, logic [2:0] l);
        logic [6:0] m = '0;
        if (f == 3'b111 && l != 3'd0) m[l - 3'd1] = 1'b1;
        return m;
    endfunction

    function automatic logic [2:0] exp_ipl(logic [6:0] p);
        logic [2:0] lv = 3'd0;
        for (int k = 0; k < 7; k++) if (p[k]) lv = 3'(k + 1);
        return ~lv;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            r_a <= '1; r_b <= '1; r_c <= '1; r_pend <= '0;
        end else begin
            r_a <= irq_n;
            r_b <= r_a;
            r_c <= r_b;
            r_pend <= (r_pend & ~served_mask(fc, ack_lvl)) | (r_c & ~r_b);
        end
    end

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        step(3);
        rst = 1'b0;
        step(1);
        // R1: idle after reset
        check(ipl_n, 3'b111, "R1");
        check({2'b00, iack}, 3'b000, "R6");

        // R2: level 3 pulse, output after third edge
        irq_n[2] = 1'b0;
        step(2);
        check(ipl_n, 3'b111, "R2 latency");
        step(1);
        check(ipl_n, 3'b100, "R2");

        // R3: line released, flag sticks
        irq_n[2] = 1'b1;
        step(4);
        check(ipl_n, 3'b100, "R3");

        // R5: level 5 outranks level 3
        irq_n[4] = 1'b0;
        step(3);
        check(ipl_n, 3'b010, "R5");
        irq_n[4] = 1'b1;

        // R6 / R7: acknowledge level 5, level 3 remains
        fc = 3'b111; ack_lvl = 3'd5;
        #0.5;
        check({2'b00, iack}, 3'b001, "R6");
        step(1);
        check(ipl_n, 3'b100, "R7");

        // R7: level 0 acknowledge clears nothing
        ack_lvl = 3'd0;
        step(2);
        check(ipl_n, 3'b100, "R7 level0");

        // R7: incomplete function code clears nothing
        fc = 3'b110; ack_lvl = 3'd3;
        #0.5;
        check({2'b00, iack}, 3'b000, "R6 fc110");
        step(2);
        check(ipl_n, 3'b100, "R7 fc110");

        // R7: serve level 3
        fc = 3'b111;
        step(1);
        check(ipl_n, 3'b111, "R7 clear");
        fc = 3'b000; ack_lvl = 3'd0;

        // R4: level 2 held low, served, no retrigger
        irq_n[1] = 1'b0;
        step(3);
        check(ipl_n, 3'b101, "R4 set");
        fc = 3'b111; ack_lvl = 3'd2;
        step(1);
        fc = 3'b000; ack_lvl = 3'd0;
        step(6);
        check(ipl_n, 3'b111, "R4");
        irq_n[1] = 1'b1;
        step(4);

        // R8: level 6 pending, fresh edge meets its own clear
        irq_n[5] = 1'b0;
        step(3);
        irq_n[5] = 1'b1;
        step(4);
        check(ipl_n, 3'b001, "R8 pre");
        irq_n[5] = 1'b0;
        step(2);
        fc = 3'b111; ack_lvl = 3'd6;
        step(1);
        fc = 3'b000; ack_lvl = 3'd0;
        check(ipl_n, 3'b001, "R8");
        irq_n[5] = 1'b1;
        step(1);
        fc = 3'b111; ack_lvl = 3'd6;
        step(1);
        fc = 3'b000; ack_lvl = 3'd0;
        step(4);
        check(ipl_n, 3'b111, "R8 post");

        // Random phase against the model (R2, R3, R5, R7)
        for (int c = 0; c < 4000; c++) begin
            for (int k = 0; k < 7; k++)
                if ($urandom_range(0, 9) == 0) irq_n[k] = ~irq_n[k];
            if ($urandom_range(0, 3) == 0) fc = 3'b111;
            else fc = 3'($urandom_range(0, 6));
            ack_lvl = 3'($urandom_range(0, 7));
            #0.5;
            check({2'b00, iack}, {2'b00, fc == 3'b111}, "R6 random");
            step(1);
            check(ipl_n, exp_ipl(r_pend), "R5 random");
        end

        finish_run();
    end

endmodule